// File: doc/BRIEF.md
# Challenge Screening Calibration Controller

This controller searches for challenges that drive a race-based arbiter circuit into unstable behaviour. It produces a sequence of wide challenge words, either by incrementing or by stepping a linear feedback shift register from a loaded seed. Each challenge is held on the challenge output while the race circuit is fired a programmable number of times. After every firing the controller waits for the response. It counts the responses that come back as 1.

When all measurements of a challenge are in, the count of ones is compared against a programmable inclusive band. A challenge whose count falls inside the band is judged unpredictable and counts as a hit. The first hits are kept in a small result memory with a combinational read port. Screening always runs to the last challenge, even when that memory is full. A missing response aborts the run with an error. A one-cycle done pulse ends every run. A typical calibration run screens about ten thousand challenges with a thousand measurements each and expects a handful of hits.

Top module: `chal_screen_ctrl`

## Requirements
- R1: After reset, launch_o, done_o, err_o, busy_o and full_o are 0 and found_o is 0.
- R2: With lfsr_mode_i = 0 at start, the challenges of a run are seed_i, seed_i+1, seed_i+2, ... (modulo 2^64).
- R3: With lfsr_mode_i = 1 at start, the first challenge is seed_i and each next challenge is (c >> 1) XOR (c[0] ? 64'hD800_0000_0000_0000 : 0).
- R4: Each challenge gets exactly num_meas_i launches. launch_o is a one-cycle pulse. No new launch is issued until resp_valid_i has been seen for the previous one, and chal_o is stable while a challenge is being measured.
- R5: A challenge is a hit when lo_thr_i <= (number of responses equal to 1) <= hi_thr_i, both bounds inclusive. When lo_thr_i > hi_thr_i, nothing is a hit.
- R6: Hits are written in screening order to addresses 0, 1, 2, ... of the result memory. rd_data_o shows the entry at rd_addr_i in the same cycle.
- R7: full_o rises once 16 hits are stored. Later hits are not written, screening goes on to the last challenge, and found_o counts every hit.
- R8: done_o is high for exactly one cycle after the last challenge is judged. found_o and full_o hold their values until the next start.
- R9: If resp_valid_i stays low for tmo_lim_i cycles after a launch, the run stops. err_o goes to 1 together with the done pulse, exactly tmo_lim_i + 2 cycles after start when the first response is missing. The next start clears err_o.
- R10: A start_i pulse while busy_o is 1 has no effect on the running screen or its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (taken only when idle) |
| lfsr_mode_i | input | 1 | 1: shift-register sequence, 0: incrementing sequence |
| seed_i | input | 64 | First challenge of the run |
| num_chal_i | input | 16 | Challenges per run (at least 1) |
| num_meas_i | input | 16 | Launches per challenge (at least 1) |
| lo_thr_i | input | 16 | Lower bound on the count of ones |
| hi_thr_i | input | 16 | Upper bound on the count of ones |
| tmo_lim_i | input | 12 | Wait cycles allowed per response (at least 1) |
| chal_o | output | 64 | Challenge to the race circuit |
| launch_o | output | 1 | Fire the race circuit |
| resp_valid_i | input | 1 | Response present |
| resp_i | input | 1 | Arbiter response bit |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Run aborted by timeout |
| found_o | output | 16 | Number of hits in the last run |
| full_o | output | 1 | Result memory holds 16 entries |
| rd_addr_i | input | 4 | Result memory read address |
| rd_data_o | output | 64 | Result memory read data |

## Verification
A behavioural race model answers each launch with a delay of one to three cycles. Its number of ones per challenge equals the challenge's low nibble, so the band checks see known counts. The band is tried in four ways. A narrow band with edge values shows whether the bounds are inclusive, and a single-value band does the same at one point. An inverted band shows that nothing is accepted. A wide band shows overflow behaviour beyond 16 hits.

Both sequence modes are run, so stored entries separate increment from shift-register stepping. A silent responder and a start pulse in the middle of a run test the abort path and the guard against restarting while busy.

// File: rtl/chal_screen_pkg.sv
package chal_screen_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_JUDGE,
    ST_FIN
  } state_e;
endpackage

// File: rtl/chal_seq_gen.sv
module chal_seq_gen #(
  parameter int unsigned W = 64,
  parameter logic [W-1:0] MASK = 64'hD800_0000_0000_0000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         lfsr_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] chal_o
);
  logic [W-1:0] chal_q, chal_nxt;
  logic         lfsr_q;

  always_comb begin
    if (lfsr_q) chal_nxt = (chal_q >> 1) ^ (chal_q[0] ? MASK : '0);
    else        chal_nxt = chal_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chal_q <= '0;
      lfsr_q <= 1'b0;
    end else if (load_i) begin
      chal_q <= seed_i;
      lfsr_q <= lfsr_i;
    end else if (step_i) begin
      chal_q <= chal_nxt;
    end
  end

  assign chal_o = chal_q;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(chal_o));
endmodule

// File: rtl/ones_judge.sv
module ones_judge #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          hit_i,
  input  logic [CW-1:0] lo_i,
  input  logic [CW-1:0] hi_i,
  output logic          pass_o
);
  logic [CW-1:0] tally_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tally_q <= '0;
    else if (clr_i)  tally_q <= '0;
    else if (hit_i)  tally_q <= tally_q + 1'b1;
  end

  assign pass_o = (tally_q >= lo_i) && (tally_q <= hi_i);

  a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ({1'b0, tally_q} <= {1'b0, $past(tally_q)} + 1'b1));
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (tally_q == '0));
endmodule

// File: rtl/hit_store.sv
module hit_store #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned NW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [NW-1:0] cnt_q;
  logic          wr_ok;

  assign full_o = (cnt_q == NW'(DEPTH));
  assign wr_ok  = wr_i && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wr_ok)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[cnt_q[AW-1:0]] <= data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];

  a_r7_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !clr_i) |=> full_o);
  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= NW'(DEPTH));
endmodule

// File: rtl/chal_screen_ctrl.sv
module chal_screen_ctrl
  import chal_screen_pkg::*;
#(
  parameter int unsigned CHAL_W = 64,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned TMO_W  = 12,
  parameter int unsigned DEPTH  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     lfsr_mode_i,
  input  logic [CHAL_W-1:0]        seed_i,
  input  logic [CNT_W-1:0]         num_chal_i,
  input  logic [CNT_W-1:0]         num_meas_i,
  input  logic [CNT_W-1:0]         lo_thr_i,
  input  logic [CNT_W-1:0]         hi_thr_i,
  input  logic [TMO_W-1:0]         tmo_lim_i,
  output logic [CHAL_W-1:0]        chal_o,
  output logic                     launch_o,
  input  logic                     resp_valid_i,
  input  logic                     resp_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     err_o,
  output logic [CNT_W-1:0]         found_o,
  output logic                     full_o,
  input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
  output logic [CHAL_W-1:0]        rd_data_o
);
  state_e           state_q;
  logic [CNT_W-1:0] nchal_q, nmeas_q, lo_q, hi_q;
  logic [CNT_W-1:0] idx_q, meas_q, found_q;
  logic [TMO_W-1:0] tmo_lim_q, tmo_q;
  logic             err_q;

  logic start_go, last_chal, last_meas, in_judge, pass;

  assign start_go  = start_i && (state_q == ST_IDLE);
  assign in_judge  = (state_q == ST_JUDGE);
  assign last_chal = (idx_q == nchal_q - 1'b1);
  assign last_meas = (meas_q == nmeas_q - 1'b1);

  chal_seq_gen #(.W(CHAL_W)) u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_go),
    .lfsr_i (lfsr_mode_i),
    .seed_i (seed_i),
    .step_i (in_judge && !last_chal),
    .chal_o (chal_o)
  );

  ones_judge #(.CW(CNT_W)) u_judge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_go || in_judge),
    .hit_i  ((state_q == ST_WAIT) && resp_valid_i && resp_i),
    .lo_i   (lo_q),
    .hi_i   (hi_q),
    .pass_o (pass)
  );

  hit_store #(.W(CHAL_W), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_go),
    .wr_i      (in_judge && pass),
    .data_i    (chal_o),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .full_o    (full_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      nchal_q   <= '0;
      nmeas_q   <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      tmo_lim_q <= '0;
      idx_q     <= '0;
      meas_q    <= '0;
      found_q   <= '0;
      tmo_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          nchal_q   <= num_chal_i;
          nmeas_q   <= num_meas_i;
          lo_q      <= lo_thr_i;
          hi_q      <= hi_thr_i;
          tmo_lim_q <= tmo_lim_i;
          idx_q     <= '0;
          meas_q    <= '0;
          found_q   <= '0;
          err_q     <= 1'b0;
          state_q   <= ST_LAUNCH;
        end
        ST_LAUNCH: begin
          tmo_q   <= '0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (resp_valid_i) begin
            if (last_meas) begin
              meas_q  <= '0;
              state_q <= ST_JUDGE;
            end else begin
              meas_q  <= meas_q + 1'b1;
              state_q <= ST_LAUNCH;
            end
          end else if (tmo_q == tmo_lim_q - 1'b1) begin
            err_q   <= 1'b1;
            state_q <= ST_FIN;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        ST_JUDGE: begin
          if (pass) found_q <= found_q + 1'b1;
          if (last_chal) begin
            state_q <= ST_FIN;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_LAUNCH;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign launch_o = (state_q == ST_LAUNCH);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_FIN);
  assign err_o    = err_q;
  assign found_o  = found_q;

  a_r4_launch_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o);
  a_r4_chal_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> $stable(chal_o));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
  a_r9_tmo_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> (tmo_q < tmo_lim_q));
  a_r10_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> ($stable(lo_q) && $stable(hi_q) && $stable(nchal_q)));
endmodule

// File: tb/chal_screen_ctrl_tb_top.sv
module chal_screen_ctrl_tb_top;
  localparam logic [63:0] MASK = 64'hD800_0000_0000_0000;

  typedef struct packed {
    logic        mode;
    logic [63:0] seed;
    logic [15:0] nchal;
    logic [15:0] nmeas;
    logic [15:0] lo;
    logic [15:0] hi;
    logic [15:0] exp_found;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 64'd0, 16'd16, 16'd16, 16'd7, 16'd9, 16'd3},
    '{1'b0, 64'd0, 16'd40, 16'd16, 16'd0, 16'd16, 16'd40},
    '{1'b1, 64'd1, 16'd8, 16'd16, 16'd0, 16'd16, 16'd8},
    '{1'b0, 64'd0, 16'd16, 16'd16, 16'd8, 16'd7, 16'd0},
    '{1'b0, 64'd5, 16'd4, 16'd20, 16'd6, 16'd6, 16'd1},
    '{1'b1, 64'hDEAD_BEEF_1234_5678, 16'd30, 16'd16, 16'd4, 16'd11, 16'hFFFF}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, mode = 1'b0, resp_valid = 1'b0, resp = 1'b0;
  logic [63:0] seed = '0;
  logic [15:0] nchal = 16'd1, nmeas = 16'd1, lo = '0, hi = '0;
  logic [11:0] tmo = 12'd20;
  logic [3:0]  rd_addr = '0;
  logic [63:0] chal, rd_data;
  logic        launch, busy, done, err, full;
  logic [15:0] found;

  int checks = 0, fails = 0, launches = 0, k = 0;
  bit resp_en = 1'b1, finished = 1'b0, new_run = 1'b0;
  logic [63:0] cur_chal = '0;

  always #5 clk = ~clk;

  chal_screen_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lfsr_mode_i(mode), .seed_i(seed),
    .num_chal_i(nchal), .num_meas_i(nmeas), .lo_thr_i(lo), .hi_thr_i(hi), .tmo_lim_i(tmo),
    .chal_o(chal), .launch_o(launch), .resp_valid_i(resp_valid), .resp_i(resp),
    .busy_o(busy), .done_o(done), .err_o(err), .found_o(found), .full_o(full),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] nxt(input logic m, input logic [63:0] c);
    return m ? ((c >> 1) ^ (c[0] ? MASK : 64'd0)) : c + 64'd1;
  endfunction

  function automatic bit is_hit(input logic [63:0] c, input logic [15:0] l, input logic [15:0] h);
    return ({12'd0, c[3:0]} >= l) && ({12'd0, c[3:0]} <= h);
  endfunction

  // race model: low nibble of the challenge = number of ones, latency 1..3
  initial begin
    forever begin
      @(negedge clk);
      resp_valid = 1'b0;
      if (launch && resp_en) begin
        if (new_run || chal != cur_chal) begin
          k = 0;
          new_run = 1'b0;
          cur_chal = chal;
        end
        resp = (k < int'(chal[3:0]));
        k++;
        launches++;
        repeat (1 + launches % 3) @(negedge clk);
        resp_valid = 1'b1;
      end
    end
  end

  task automatic run(input vec_t v, input bit disturb, output int cyc);
    mode = v.mode; seed = v.seed; nchal = v.nchal; nmeas = v.nmeas; lo = v.lo; hi = v.hi;
    launches = 0; new_run = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 1;
    while (!done && cyc < 50000) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 30) begin
        start = 1'b1; seed = 64'h99; lo = 16'd0; hi = 16'd16;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
  endtask

  task automatic check_mem(input vec_t v, input string req);
    logic [63:0] c = v.seed;
    int n = 0;
    for (int i = 0; i < int'(v.nchal); i++) begin
      if (is_hit(c, v.lo, v.hi)) begin
        if (n < 16) begin
          rd_addr = 4'(n);
          #1;
          chk(rd_data == c, req, rd_data, c);
        end
        n++;
      end
      c = nxt(v.mode, c);
    end
    chk(found == 16'(n), "R5 found vs model", found, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int cyc;
    #2;
    chk(!launch && !done && !err && !busy && !full && found == 0, "R1 reset state",
        {launch, done, err, busy, full, found}, 0);
    #30 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !full && found == 0, "R1 after release",
        {busy, done, err, full, found}, 0);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i], 1'b0, cyc);
      chk(done == 1'b1, "R8 done seen", done, 1);
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", done, 0);
      chk(err == 1'b0, "R9 no error", err, 0);
      chk(launches == int'(VECS[i].nchal) * int'(VECS[i].nmeas), "R4 launch count",
          launches, int'(VECS[i].nchal) * int'(VECS[i].nmeas));
      if (VECS[i].exp_found != 16'hFFFF)
        chk(found == VECS[i].exp_found, "R5 found vs table", found, VECS[i].exp_found);
      chk(full == (found >= 16), "R7 full flag", full, found >= 16);
      check_mem(VECS[i], VECS[i].mode ? "R3 R6 lfsr entry" : "R2 R6 counter entry");
      repeat (3) @(negedge clk);
      chk(found == VECS[i].exp_found || VECS[i].exp_found == 16'hFFFF, "R8 found held",
          found, VECS[i].exp_found);
    end

    // R7: 40 hits with 16 slots; entry 15 must be challenge 15, not a later one
    rd_addr = 4'd15;
    run(VECS[1], 1'b0, cyc);
    @(negedge clk);
    #1 chk(rd_data == 64'd15 && found == 16'd40, "R7 overflow not written", rd_data, 15);

    // R10: start pulse mid-run must not alter the screen
    run(VECS[4], 1'b1, cyc);
    @(negedge clk);
    chk(found == 16'd1, "R10 found after mid-run start", found, 1);
    rd_addr = 4'd0;
    #1 chk(rd_data == 64'd6, "R10 entry after mid-run start", rd_data, 6);

    // R9: silent responder
    resp_en = 1'b0;
    tmo = 12'd10;
    run(VECS[0], 1'b0, cyc);
    chk(done && err, "R9 abort with error", {done, err}, 2'b11);
    chk(cyc == 12, "R9 abort timing", cyc, 12);
    chk(found == 16'd0, "R9 nothing found", found, 0);
    @(negedge clk);
    resp_en = 1'b1;
    tmo = 12'd20;
    run(VECS[4], 1'b0, cyc);
    @(negedge clk);
    chk(err == 1'b0 && found == 16'd1, "R9 error cleared by start", {err, found}, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule